// File: doc/BRIEF.md
# Configurable Status Output Pin Controller

This block drives three general-purpose digital status pins. Each pin has its own small configuration register. The register holds a 6-bit signal-select code and an invert bit. On every clock the block picks one internal status signal per pin, applies the invert bit, and registers the result. It registers an output enable for each pin in the same way. The registered enable lets a pad either drive or float the line. The whole block runs on the oscillator clock. After reset, pin 0 carries that clock divided by 192.

Pin 1 shares its physical line with the SPI serial data output. It therefore drives its programmed function only while the SPI chip select is high. Select code 0x2E floats a pin in every state.

A two-state sleep controller tracks the device's sleep condition. The state `ST_AWAKE` moves to `ST_HELD` on any clock edge where `sleep_i` is sampled high. The state `ST_HELD` returns to `ST_AWAKE` only on an edge where `chip_rdy_n_i` is sampled low. While the controller is held, every pin whose select code is below 0x20 is forced to a fixed level, and codes of 0x20 and above keep working as programmed.

Top module: `stpin_ctrl`

## Requirements
- R1: A clock edge with `cfg_we_i[i]` high loads `cfg_wdata_i` into pin i's register. Bits [5:0] are the select code and bit 6 is the invert bit. The pin output reflects the new setting from the following edge onward.
- R2: While `rst_ni` is low, all pin values and output enables are 0. The register defaults are: pin 0 select 0x3F (divided clock), pin 1 select 0x2E (high impedance) and pin 2 select 0x2F (constant). All invert bits default to 0.
- R3: A select code s below 0x20 drives `status_i[s]` XOR invert, registered by one edge. Codes at or above the status width drive 0 XOR invert.
- R4: Select codes from 0x20 to 0x3F, other than 0x2E and 0x3F, drive 0 XOR invert with the enable high.
- R5: Select code 0x2E gives enable 0 and value 0 in every state, whatever the invert bit.
- R6: Select code 0x3F drives the oscillator clock divided by 192 XOR invert. The divided clock starts low after reset and toggles on every 96th edge, first at edge 96. The pin shows each toggle one edge later.
- R7: When `spi_cs_n_i` is sampled low, pin 1 has enable 0 and value 0 after that edge.
- R8: Sampling `sleep_i` high enters the held state. While held, pins with a select code below 0x20 drive with enable high. Pins 0 and 2 drive their invert bit and pin 1 drives the complement of its invert bit.
- R9: The held state ends only at an edge where `chip_rdy_n_i` is sampled low. Lowering `sleep_i` alone does not release it.
- R10: Select codes of 0x20 and above behave the same in the held state as when awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 3 | Per-pin configuration write strobe |
| cfg_wdata_i | input | 7 | Configuration data: [5:0] select, [6] invert |
| status_i | input | NSTAT (16) | Internal status signals |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| sleep_i | input | 1 | Device sleep request |
| chip_rdy_n_i | input | 1 | Chip ready, active low |
| pin_o | output | 3 | Pin output values |
| pin_oe_o | output | 3 | Pin output enables |

## Verification
The hardest situation to reach is the held state with pin 1 forced to the opposite polarity. Getting there needs four conditions at once:
- a select code below 0x20,
- a chosen invert bit,
- a high chip select,
- a chip-ready line that stays high after sleep is lowered.

Directed sequences set this up explicitly. They then release the state only through the chip-ready line. Randomized phases mix sleep, chip-ready and chip-select toggling with configuration writes, including writes made while the state is held. A long idle run covers the divided-clock edges.

// File: rtl/stpin_pkg.sv
package stpin_pkg;

    localparam int NPINS  = 3;
    localparam int SEL_W  = 6;
    localparam int CFG_W  = SEL_W + 1;

    localparam logic [SEL_W-1:0] SEL_FORCE_LIMIT = 6'h20;
    localparam logic [SEL_W-1:0] SEL_FLOAT       = 6'h2E;
    localparam logic [SEL_W-1:0] SEL_DIVCLK      = 6'h3F;

    typedef struct packed {
        logic             inv;
        logic [SEL_W-1:0] sel;
    } pin_cfg_t;

    typedef enum logic {
        ST_AWAKE = 1'b0,
        ST_HELD  = 1'b1
    } sleep_st_t;

endpackage

// File: rtl/stpin_divclk.sv
module stpin_divclk #(
    parameter int DIV = 192
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic div_o
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          div_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_o = div_q;

endmodule

// File: rtl/stpin_sleep_fsm.sv
module stpin_sleep_fsm
    import stpin_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_i,
    input  logic chip_rdy_n_i,
    output logic held_o
);

    sleep_st_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_AWAKE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: if (sleep_i)       state_d = ST_HELD;
            ST_HELD:  if (!chip_rdy_n_i) state_d = ST_AWAKE;
            default:                     state_d = ST_AWAKE;
        endcase
    end

    assign held_o = (state_q == ST_HELD);

endmodule

// File: rtl/stpin_pin_sel.sv
module stpin_pin_sel
    import stpin_pkg::*;
#(
    parameter int NSTAT      = 16,
    parameter bit FORCE_FLIP = 1'b0
) (
    input  pin_cfg_t         cfg_i,
    input  logic [NSTAT-1:0] status_i,
    input  logic             divclk_i,
    input  logic             held_i,
    input  logic             line_free_i,
    output logic             val_o,
    output logic             oe_o
);

    logic [31:0] stat_pad;
    logic        sig;

    assign stat_pad = 32'(status_i);

    always_comb begin
        if (cfg_i.sel < SEL_FORCE_LIMIT) sig = stat_pad[cfg_i.sel[4:0]];
        else if (cfg_i.sel == SEL_DIVCLK) sig = divclk_i;
        else                              sig = 1'b0;
    end

    always_comb begin
        if (!line_free_i || cfg_i.sel == SEL_FLOAT) begin
            val_o = 1'b0;
            oe_o  = 1'b0;
        end else if (held_i && cfg_i.sel < SEL_FORCE_LIMIT) begin
            val_o = cfg_i.inv ^ FORCE_FLIP;
            oe_o  = 1'b1;
        end else begin
            val_o = sig ^ cfg_i.inv;
            oe_o  = 1'b1;
        end
    end

endmodule

// File: rtl/stpin_ctrl.sv
module stpin_ctrl
    import stpin_pkg::*;
#(
    parameter int          NSTAT      = 16,
    parameter int          CLK_DIV    = 192,
    parameter logic [6:0]  P0_DEFAULT = 7'h3F,
    parameter logic [6:0]  P1_DEFAULT = 7'h2E,
    parameter logic [6:0]  P2_DEFAULT = 7'h2F
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       cfg_we_i,
    input  logic [6:0]       cfg_wdata_i,
    input  logic [NSTAT-1:0] status_i,
    input  logic             spi_cs_n_i,
    input  logic             sleep_i,
    input  logic             chip_rdy_n_i,
    output logic [2:0]       pin_o,
    output logic [2:0]       pin_oe_o
);

    logic [NPINS-1:0][CFG_W-1:0] cfg_q;
    logic [NPINS-1:0]            val_d, oe_d;
    logic [NPINS-1:0]            pin_q, oe_q;
    logic                        divclk;
    logic                        held;

    stpin_divclk #(.DIV(CLK_DIV)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_o  (divclk)
    );

    stpin_sleep_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sleep_i      (sleep_i),
        .chip_rdy_n_i (chip_rdy_n_i),
        .held_o       (held)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        localparam logic [CFG_W-1:0] RST_V =
            (g == 0) ? P0_DEFAULT : (g == 1) ? P1_DEFAULT : P2_DEFAULT;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          cfg_q[g] <= RST_V;
            else if (cfg_we_i[g]) cfg_q[g] <= cfg_wdata_i;
        end

        stpin_pin_sel #(
            .NSTAT      (NSTAT),
            .FORCE_FLIP (g == 1)
        ) u_sel (
            .cfg_i       (pin_cfg_t'(cfg_q[g])),
            .status_i    (status_i),
            .divclk_i    (divclk),
            .held_i      (held),
            .line_free_i ((g == 1) ? spi_cs_n_i : 1'b1),
            .val_o       (val_d[g]),
            .oe_o        (oe_d[g])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q <= '0;
            oe_q  <= '0;
        end else begin
            pin_q <= val_d;
            oe_q  <= oe_d;
        end
    end

    assign pin_o    = pin_q;
    assign pin_oe_o = oe_q;

endmodule

// File: rtl/stpin_ctrl_chk.sv
module stpin_ctrl_chk (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             spi_cs_n_i,
    input logic             sleep_i,
    input logic             chip_rdy_n_i,
    input logic             held_i,
    input logic [2:0][6:0]  cfg_i,
    input logic [2:0]       pin_o,
    input logic [2:0]       pin_oe_o
);

    p_spi_share_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_oe_o[1] |-> $past(spi_cs_n_i));

    p_float_p0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_i[0][5:0]) == 6'h2E) |-> !pin_oe_o[0]);

    p_float_p2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_i[2][5:0]) == 6'h2E) |-> !pin_oe_o[2]);

    p_force_p0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(held_i) && $past(cfg_i[0][5:0]) < 6'h20)
        |-> (pin_oe_o[0] && pin_o[0] == $past(cfg_i[0][6])));

    p_force_p1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(held_i) && $past(spi_cs_n_i) && $past(cfg_i[1][5:0]) < 6'h20)
        |-> (pin_oe_o[1] && pin_o[1] != $past(cfg_i[1][6])));

    p_hold_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(held_i) |-> $past(sleep_i));

    p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(held_i) |-> !$past(chip_rdy_n_i));

endmodule

bind stpin_ctrl stpin_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spi_cs_n_i   (spi_cs_n_i),
    .sleep_i      (sleep_i),
    .chip_rdy_n_i (chip_rdy_n_i),
    .held_i       (held),
    .cfg_i        (cfg_q),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
);

// File: tb/sim_stpin_ctrl.sv
`timescale 1ns/1ps
module sim_stpin_ctrl;

    localparam int NSTAT = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       we = '0;
    logic [6:0]       wdata = '0;
    logic [NSTAT-1:0] stat = '0;
    logic             cs_n = 1'b1;
    logic             sleep = 1'b0;
    logic             rdy_n = 1'b1;
    logic [2:0]       pin, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [6:0] cfg_m [3];
    logic       held_m;
    int         cnt_m;
    logic       div_m;

    always #4 clk = ~clk;

    stpin_ctrl #(.NSTAT(NSTAT)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
        .status_i(stat), .spi_cs_n_i(cs_n), .sleep_i(sleep),
        .chip_rdy_n_i(rdy_n), .pin_o(pin), .pin_oe_o(pin_oe)
    );

    // returns {oe, value} per the requirements
    function automatic logic [1:0] pin_exp(int p, logic [6:0] c, logic h,
                                           logic [NSTAT-1:0] st, logic dv, logic cs);
        logic [5:0] s;
        logic iv, sg;
        s  = c[5:0];
        iv = c[6];
        if (p == 1 && !cs) return 2'b00;                     // R7
        if (s == 6'h2E)    return 2'b00;                     // R5
        if (h && s < 6'h20) return {1'b1, (p == 1) ? ~iv : iv}; // R8
        if (s < 6'h20)      sg = (int'(s) < NSTAT) ? st[s] : 1'b0; // R3
        else if (s == 6'h3F) sg = dv;                        // R6
        else                 sg = 1'b0;                      // R4
        return {1'b1, sg ^ iv};
    endfunction

    task automatic check(string tag, logic [2:0] ev, logic [2:0] eo);
        checks++;
        if (pin !== ev || pin_oe !== eo) begin
            fails++;
            $display("FAIL %s: pin=%b oe=%b expected pin=%b oe=%b", tag, pin, pin_oe, ev, eo);
        end
    endtask

    task automatic step(string tag);
        logic [2:0] ev, eo;
        for (int p = 0; p < 3; p++) begin
            logic [1:0] r;
            r = pin_exp(p, cfg_m[p], held_m, stat, div_m, cs_n);
            eo[p] = r[1];
            ev[p] = r[0];
        end
        @(posedge clk);
        for (int p = 0; p < 3; p++) if (we[p]) cfg_m[p] = wdata;
        held_m = held_m ? rdy_n : sleep;
        if (cnt_m == 95) begin cnt_m = 0; div_m = ~div_m; end
        else cnt_m++;
        @(negedge clk);
        check(tag, ev, eo);
        we = '0;
    endtask

    task automatic wr(int p, logic [5:0] sel, logic inv, string tag);
        we = 3'(1 << p);
        wdata = {inv, sel};
        step(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        cfg_m[0] = 7'h3F; cfg_m[1] = 7'h2E; cfg_m[2] = 7'h2F;
        held_m = 1'b0; cnt_m = 0; div_m = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", 3'b000, 3'b000);              // reset state
        rst_n = 1'b1;
        step("R2");                               // defaults visible
        for (int i = 0; i < 220; i++) step("R6"); // divided clock edges

        // R1/R3: status routing with invert
        wr(0, 6'd3, 1'b0, "R1");
        stat = 16'h0008; step("R1");
        stat = 16'h0000; step("R3");
        wr(0, 6'd3, 1'b1, "R1");
        step("R3");
        wr(2, 6'd15, 1'b0, "R3");
        stat = 16'h8000; step("R3");
        wr(2, 6'd20, 1'b1, "R3");                 // beyond status width
        stat = 16'hFFFF; step("R3");
        // R4
        wr(0, 6'h25, 1'b1, "R4");
        step("R4");
        wr(0, 6'h2F, 1'b0, "R4");
        step("R4");
        // R5
        wr(2, 6'h2E, 1'b1, "R5");
        step("R5");
        sleep = 1'b1; step("R5"); step("R5");
        sleep = 1'b0; rdy_n = 1'b0; step("R5"); rdy_n = 1'b1;
        // R7
        wr(1, 6'd2, 1'b0, "R7");
        stat = 16'h0004; step("R7");
        cs_n = 1'b0; step("R7"); step("R7");
        cs_n = 1'b1; step("R7");

        // R8/R9: held with pin1 opposite polarity
        wr(0, 6'd5, 1'b1, "R8");
        wr(1, 6'd5, 1'b1, "R8");
        wr(2, 6'd5, 1'b0, "R8");
        stat = 16'h0020;
        sleep = 1'b1; step("R8"); step("R8");
        stat = 16'h0000; step("R8");
        sleep = 1'b0; step("R9"); step("R9"); step("R9");
        rdy_n = 1'b0; step("R9"); step("R9");
        rdy_n = 1'b1; step("R9");

        // R10: codes >= 0x20 run while held
        wr(2, 6'h3F, 1'b0, "R10");
        wr(0, 6'h3F, 1'b1, "R10");
        sleep = 1'b1; step("R10");
        sleep = 1'b0;
        for (int i = 0; i < 200; i++) step("R10");
        rdy_n = 1'b0; step("R10"); rdy_n = 1'b1;

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            stat  = NSTAT'($urandom);
            cs_n  = ($urandom % 5) != 0;
            sleep = ($urandom % 12) == 0;
            rdy_n = ($urandom % 6) != 0;
            if ($urandom % 4 == 0) begin
                logic [5:0] s;
                case ($urandom % 4)
                    0: s = 6'($urandom % 32);
                    1: s = 6'h2E;
                    2: s = 6'h3F;
                    default: s = 6'(32 + $urandom % 32);
                endcase
                we = 3'(1 << ($urandom % 3));
                wdata = {1'($urandom), s};
            end
            step((i % 2) ? "R8" : "R3");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule